// File: doc/BRIEF.md
# Self-Calibrating Current-Converter Sequencer

This block is a bus master that runs a current-sense converter peripheral through its register controller. A `start` pulse makes it read three identification bytes and reject a peripheral whose type, subtype or revision is too low. It then updates a protected reset-control register under an unlock key and runs three calibration conversions. These capture a gain reference and two offsets, and the block checks that neither offset equals the gain.

Once calibration has passed, the sequencer accepts measurement requests on channel 0 (internal sense resistor) or channel 1 (external sense resistor). It returns each 16-bit raw sample. Scaling to amperes is left to the consumer.

Every conversion is set up by a fixed series of register writes. The sequencer then waits for end-of-conversion, either by polling a status byte a bounded number of times, or by waiting for an interrupt and confirming it with one status read. It reads the result as two bytes, low byte first. Finally it clears the converter enable, and it does this on the failure paths too. Each operation ends with a one-cycle `done` pulse that carries an error flag and a code.

Top module: `cal_conv_seq`

Register addresses used (8-bit): type 0x01, subtype 0x02, revision 0x03, status 0x08, mode 0x10, channel 0x11, decimation 0x12, settle 0x13, averaging control 0x14, averaging enable 0x15, converter enable 0x16, conversion request 0x17, data low 0x20, data high 0x21, unlock key 0x30, reset control 0x31.

## Requirements
- R1: After `start`, the bytes at 0x01, 0x02 and 0x03 are read and compared with 8, 3 and 1 in that order. A value below its minimum ends the operation with error code 1, 2 or 3 respectively, and no register write is made.
- R2: With identification passed, the first writes are 0xA5 to 0x30, then 0xA5 to 0x30 again, then to 0x31 the value read from 0x31 with bit 2 set. The read of 0x31 occurs between the two key writes.
- R3: Calibration converts channel 3 (gain reference), then channel 6 (internal offset), then channel 5 (external offset). The samples appear on `cal_gain`, `cal_off_int` and `cal_off_ext`, and `cal_ok` rises on success.
- R4: When the internal offset equals the gain reference, calibration ends with code 5 before the external offset conversion. When the external offset equals the gain reference, it ends with code 6. In both cases `cal_ok` stays low.
- R5: Each conversion writes, in this order: 0x01 to 0x10; the channel number to 0x11; 0x00 to 0x12; 0x00 to 0x13; AVG_LOG2 to 0x14; 0x00 to 0x15 (0x80 when AVG_LOG2 is non-zero); 0x80 to 0x16; 0x80 to 0x17.
- R6: In polling mode (`use_irq`=0), status 0x08 is read up to RETRY = 2·2^AVG_LOG2 times, with CONV_CYC idle cycles between reads. Completion is status bits [1:0] equal to 01, and the upper status bits are ignored. If no read shows completion, the operation ends with code 4.
- R7: In interrupt mode, the sequencer waits up to BUDGET = 2·2^AVG_LOG2·CONV_CYC cycles for `eoc_irq`, and then reads status 0x08 exactly once. Code 4 results if the interrupt does not arrive or if the confirming status does not have [1:0]=01. No status read is made when the interrupt does not arrive.
- R8: Every conversion attempt ends with a write of 0x00 to 0x16, whether the attempt passed or failed.
- R9: A measurement on channel `meas_ch` presents {byte at 0x21, byte at 0x20} on `result` with `err` low.
- R10: `ready` is high only when the sequencer is idle, and the bus is quiet then. `meas_req` is ignored while the sequencer is busy or uncalibrated, and no bus traffic follows it.
- R11: `done` is a one-cycle pulse. `err` is high with it exactly when `err_code` is non-zero, and a success carries code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Run identification, reset update and calibration |
| meas_req | input | 1 | Measurement request |
| meas_ch | input | 1 | Measurement channel: 0 internal, 1 external sense |
| use_irq | input | 1 | 1: wait for interrupt then confirm, 0: poll status |
| eoc_irq | input | 1 | End-of-conversion interrupt from the peripheral |
| ready | output | 1 | Idle, accepting a request |
| bus_req | output | 1 | Register access request, held until acknowledge |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | 8 | Register address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Access complete, read data valid |
| bus_rdata | input | 8 | Read data |
| result | output | 16 | Raw sample of the last measurement |
| cal_gain | output | 16 | Gain reference sample |
| cal_off_int | output | 16 | Internal offset sample |
| cal_off_ext | output | 16 | External offset sample |
| cal_ok | output | 1 | Calibration completed and passed |
| done | output | 1 | Operation finished (one cycle) |
| err | output | 1 | Operation failed |
| err_code | output | 3 | 0 ok, 1 type, 2 subtype, 3 revision, 4 timeout, 5/6 offset equals gain |

## Verification
The bench builds the block with CONV_CYC=8 and AVG_LOG2=0. This gives a 16-cycle interrupt budget and two polling reads, so completing on the first read, completing on the last read, and running out of reads can all be reached by sweeping the number of not-ready replies from 0 to 2. The identification sweep covers all eight combinations of each byte just below and at its threshold. A register model logs every write, so the configuration order and the closing disable can be compared entry by entry for both measurement channels and for the failure paths.

// File: rtl/csq_pkg.sv
package csq_pkg;
  localparam logic [7:0] A_TYPE   = 8'h01;
  localparam logic [7:0] A_SUB    = 8'h02;
  localparam logic [7:0] A_REV    = 8'h03;
  localparam logic [7:0] A_STAT   = 8'h08;
  localparam logic [7:0] A_MODE   = 8'h10;
  localparam logic [7:0] A_CHAN   = 8'h11;
  localparam logic [7:0] A_DEC    = 8'h12;
  localparam logic [7:0] A_SETTLE = 8'h13;
  localparam logic [7:0] A_AVGC   = 8'h14;
  localparam logic [7:0] A_AVGE   = 8'h15;
  localparam logic [7:0] A_EN     = 8'h16;
  localparam logic [7:0] A_REQ    = 8'h17;
  localparam logic [7:0] A_DLO    = 8'h20;
  localparam logic [7:0] A_DHI    = 8'h21;
  localparam logic [7:0] A_KEY    = 8'h30;
  localparam logic [7:0] A_RSTC   = 8'h31;

  localparam logic [7:0] KEY_VAL  = 8'hA5;
  localparam logic [7:0] ON_VAL   = 8'h80;
  localparam logic [7:0] TRIM_VAL = 8'h01;

  localparam logic [7:0] CH_GAIN  = 8'd3;
  localparam logic [7:0] CH_OFFI  = 8'd6;
  localparam logic [7:0] CH_OFFE  = 8'd5;

  localparam logic [2:0] E_NONE = 3'd0;
  localparam logic [2:0] E_TYPE = 3'd1;
  localparam logic [2:0] E_SUB  = 3'd2;
  localparam logic [2:0] E_REV  = 3'd3;
  localparam logic [2:0] E_TMO  = 3'd4;
  localparam logic [2:0] E_OFFI = 3'd5;
  localparam logic [2:0] E_OFFE = 3'd6;

  typedef enum logic [3:0] {
    S_IDLE, S_ID, S_RST, S_CFG, S_WAIT, S_POLL, S_SLEEP, S_RD, S_OFF, S_CHK, S_FIN
  } state_t;

  typedef enum logic [1:0] {PH_GAIN, PH_OFFI, PH_OFFE, PH_MEAS} phase_t;
endpackage

// File: rtl/csq_bus_port.sv
module csq_bus_port #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic          cmd_we,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (bus_req) begin
        if (bus_ack) begin
          bus_req   <= 1'b0;
          rsp_valid <= 1'b1;
          rsp_data  <= bus_rdata;
        end
      end else if (cmd_valid) begin
        bus_req   <= 1'b1;
        bus_we    <= cmd_we;
        bus_addr  <= cmd_addr;
        bus_wdata <= cmd_wdata;
      end
    end
  end

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we)); // R5
endmodule

// File: rtl/csq_timer.sv
module csq_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          zero
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  AST_TMR_STEP: assert property (@(posedge clk) disable iff (rst)
    !load && cnt != '0 |=> cnt == $past(cnt) - 1'b1); // R6
endmodule

// File: rtl/cal_conv_seq.sv
module cal_conv_seq
  import csq_pkg::*;
#(
  parameter int CONV_CYC = 16,
  parameter int AVG_LOG2 = 0,
  parameter int TYPE_MIN = 8,
  parameter int SUB_MIN  = 3,
  parameter int REV_MIN  = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        meas_req,
  input  logic        meas_ch,
  input  logic        use_irq,
  input  logic        eoc_irq,
  output logic        ready,
  output logic        bus_req,
  output logic        bus_we,
  output logic [7:0]  bus_addr,
  output logic [7:0]  bus_wdata,
  input  logic        bus_ack,
  input  logic [7:0]  bus_rdata,
  output logic [15:0] result,
  output logic [15:0] cal_gain,
  output logic [15:0] cal_off_int,
  output logic [15:0] cal_off_ext,
  output logic        cal_ok,
  output logic        done,
  output logic        err,
  output logic [2:0]  err_code
);
  localparam int BUDGET = (1 << AVG_LOG2) * CONV_CYC * 2;
  localparam int RETRY  = BUDGET / CONV_CYC;
  localparam int TW     = $clog2(BUDGET + 1);
  localparam int RW     = $clog2(RETRY + 1);
  localparam logic [7:0] AVGE_VAL = (AVG_LOG2 != 0) ? ON_VAL : 8'h00;

  state_t        state;
  phase_t        ph;
  logic [2:0]    step;
  logic          pend;
  logic          ch_q;
  logic [7:0]    rst_val;
  logic [7:0]    lo_q;
  logic [RW-1:0] retries;
  logic [2:0]    code_q;
  logic          irq_seen;

  logic          cmd_valid, cmd_we, rsp_valid;
  logic [7:0]    cmd_addr, cmd_wdata, rsp_data, cur_chan;
  logic          tmr_load, tmr_zero, eoc_ok;
  logic [TW-1:0] tmr_val;

  csq_bus_port #(.AW(8), .DW(8)) u_port (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_we(cmd_we), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  csq_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .val(tmr_val), .zero(tmr_zero)
  );

  always_comb begin
    case (ph)
      PH_GAIN: cur_chan = CH_GAIN;
      PH_OFFI: cur_chan = CH_OFFI;
      PH_OFFE: cur_chan = CH_OFFE;
      default: cur_chan = {7'd0, ch_q};
    endcase
  end

  // Register access issued by each bus-using state and step
  always_comb begin
    cmd_we    = 1'b1;
    cmd_addr  = 8'h00;
    cmd_wdata = 8'h00;
    case (state)
      S_ID: begin
        cmd_we   = 1'b0;
        cmd_addr = (step == 3'd0) ? A_TYPE : (step == 3'd1) ? A_SUB : A_REV;
      end
      S_RST: begin
        case (step)
          3'd0:    begin cmd_addr = A_KEY;  cmd_wdata = KEY_VAL; end
          3'd1:    begin cmd_we = 1'b0; cmd_addr = A_RSTC; end
          3'd2:    begin cmd_addr = A_KEY;  cmd_wdata = KEY_VAL; end
          default: begin cmd_addr = A_RSTC; cmd_wdata = rst_val | 8'h04; end
        endcase
      end
      S_CFG: begin
        case (step)
          3'd0:    begin cmd_addr = A_MODE;   cmd_wdata = TRIM_VAL; end
          3'd1:    begin cmd_addr = A_CHAN;   cmd_wdata = cur_chan; end
          3'd2:    begin cmd_addr = A_DEC;    cmd_wdata = 8'h00; end
          3'd3:    begin cmd_addr = A_SETTLE; cmd_wdata = 8'h00; end
          3'd4:    begin cmd_addr = A_AVGC;   cmd_wdata = 8'(AVG_LOG2); end
          3'd5:    begin cmd_addr = A_AVGE;   cmd_wdata = AVGE_VAL; end
          3'd6:    begin cmd_addr = A_EN;     cmd_wdata = ON_VAL; end
          default: begin cmd_addr = A_REQ;    cmd_wdata = ON_VAL; end
        endcase
      end
      S_POLL: begin cmd_we = 1'b0; cmd_addr = A_STAT; end
      S_RD:   begin cmd_we = 1'b0; cmd_addr = (step == 3'd0) ? A_DLO : A_DHI; end
      S_OFF:  begin cmd_addr = A_EN; cmd_wdata = 8'h00; end
      default: ;
    endcase
  end

  assign cmd_valid = !pend && (state == S_ID || state == S_RST || state == S_CFG ||
                               state == S_POLL || state == S_RD || state == S_OFF);
  assign eoc_ok    = (rsp_data[1:0] == 2'b01);
  assign tmr_load  = rsp_valid &&
                     ((state == S_CFG && step == 3'd7 && use_irq) ||
                      (state == S_POLL && !eoc_ok && retries != RW'(1)));
  assign tmr_val   = (state == S_CFG) ? TW'(BUDGET) : TW'(CONV_CYC);
  assign ready     = (state == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst || state == S_CFG) irq_seen <= 1'b0;
    else if (eoc_irq)          irq_seen <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; ph <= PH_GAIN; step <= '0; pend <= 1'b0; ch_q <= 1'b0;
      rst_val <= '0; lo_q <= '0; retries <= '0; code_q <= E_NONE;
      result <= '0; cal_gain <= '0; cal_off_int <= '0; cal_off_ext <= '0;
      cal_ok <= 1'b0; done <= 1'b0; err <= 1'b0; err_code <= E_NONE;
    end else begin
      done <= 1'b0;
      if (cmd_valid) pend <= 1'b1;
      if (rsp_valid) pend <= 1'b0;
      case (state)
        S_IDLE: begin
          code_q <= E_NONE;
          step   <= '0;
          if (start) begin
            cal_ok <= 1'b0;
            state  <= S_ID;
          end else if (meas_req && cal_ok) begin
            ch_q  <= meas_ch;
            ph    <= PH_MEAS;
            state <= S_CFG;
          end
        end
        S_ID: if (rsp_valid) begin
          step <= step + 3'd1;
          if (step == 3'd0 && rsp_data < 8'(TYPE_MIN)) begin
            code_q <= E_TYPE; state <= S_FIN;
          end else if (step == 3'd1 && rsp_data < 8'(SUB_MIN)) begin
            code_q <= E_SUB; state <= S_FIN;
          end else if (step == 3'd2) begin
            step <= '0;
            if (rsp_data < 8'(REV_MIN)) begin
              code_q <= E_REV; state <= S_FIN;
            end else state <= S_RST;
          end
        end
        S_RST: if (rsp_valid) begin
          step <= step + 3'd1;
          if (step == 3'd1) rst_val <= rsp_data;
          if (step == 3'd3) begin
            step  <= '0;
            ph    <= PH_GAIN;
            state <= S_CFG;
          end
        end
        S_CFG: if (rsp_valid) begin
          step <= step + 3'd1;
          if (step == 3'd7) begin
            step    <= '0;
            retries <= use_irq ? RW'(1) : RW'(RETRY);
            state   <= use_irq ? S_WAIT : S_POLL;
          end
        end
        S_WAIT: begin
          if (irq_seen)      state <= S_POLL;
          else if (tmr_zero) begin code_q <= E_TMO; state <= S_OFF; end
        end
        S_POLL: if (rsp_valid) begin
          if (eoc_ok)                    state <= S_RD;
          else if (retries == RW'(1)) begin code_q <= E_TMO; state <= S_OFF; end
          else begin
            retries <= retries - RW'(1);
            state   <= S_SLEEP;
          end
        end
        S_SLEEP: if (tmr_zero) state <= S_POLL;
        S_RD: if (rsp_valid) begin
          step <= step + 3'd1;
          if (step == 3'd0) lo_q <= rsp_data;
          else begin
            step  <= '0;
            state <= S_OFF;
            case (ph)
              PH_GAIN: cal_gain    <= {rsp_data, lo_q};
              PH_OFFI: cal_off_int <= {rsp_data, lo_q};
              PH_OFFE: cal_off_ext <= {rsp_data, lo_q};
              default: result      <= {rsp_data, lo_q};
            endcase
          end
        end
        S_OFF: if (rsp_valid) state <= S_CHK;
        S_CHK: begin
          state <= S_FIN;
          if (code_q == E_NONE) begin
            case (ph)
              PH_GAIN: begin ph <= PH_OFFI; state <= S_CFG; end
              PH_OFFI: begin
                if (cal_off_int == cal_gain) code_q <= E_OFFI;
                else begin ph <= PH_OFFE; state <= S_CFG; end
              end
              PH_OFFE: begin
                if (cal_off_ext == cal_gain) code_q <= E_OFFE;
                else cal_ok <= 1'b1;
              end
              default: ;
            endcase
          end
        end
        S_FIN: begin
          done     <= 1'b1;
          err      <= (code_q != E_NONE);
          err_code <= code_q;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R11
  AST_ERR_MATCH:  assert property (@(posedge clk) disable iff (rst) done |-> (err == (err_code != 3'd0))); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) ready |-> !bus_req); // R10
  AST_CAL_SANE:   assert property (@(posedge clk) disable iff (rst)
    cal_ok |-> (cal_gain != cal_off_int) && (cal_gain != cal_off_ext)); // R4
endmodule

// File: tb/sim_cal_conv_seq.sv
`timescale 1ns/1ps
module sim_cal_conv_seq;
  localparam int CONV_CYC = 8;
  localparam int AVG_LOG2 = 0;

  logic clk = 1'b0, rst = 1'b1;
  logic start = 0, meas_req = 0, meas_ch = 0, use_irq = 0, eoc_irq;
  logic ready, bus_req, bus_we, bus_ack, cal_ok, done, err;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;
  logic [15:0] result, cal_gain, cal_off_int, cal_off_ext;
  logic [2:0] err_code;

  always #2 clk = ~clk;

  cal_conv_seq #(.CONV_CYC(CONV_CYC), .AVG_LOG2(AVG_LOG2)) u0 (
    .clk(clk), .rst(rst), .start(start), .meas_req(meas_req), .meas_ch(meas_ch),
    .use_irq(use_irq), .eoc_irq(eoc_irq), .ready(ready),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .result(result), .cal_gain(cal_gain),
    .cal_off_int(cal_off_int), .cal_off_ext(cal_off_ext), .cal_ok(cal_ok),
    .done(done), .err(err), .err_code(err_code)
  );

  // Register model settings, driven by the stimulus process
  logic [7:0]  type_v = 8, sub_v = 3, rev_v = 1;
  logic [15:0] gain_v = 16'h4000, oi_v = 16'h0100, oe_v = 16'h0180, m0_v = 0, m1_v = 0;
  int          poll_dly = 0, irq_dly = 0;
  logic        bad_stat = 0;

  // Register model state
  logic [7:0]  rstc, chan_r, wn;
  logic [15:0] cv;
  int          pl, ic, stat_rd, dn_cnt;
  logic [7:0]  wl_a [256];
  logic [7:0]  wl_d [256];

  function automatic logic [15:0] pick(input logic [7:0] c);
    case (c)
      8'd3: return gain_v;
      8'd6: return oi_v;
      8'd5: return oe_v;
      8'd1: return m1_v;
      default: return m0_v;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      bus_ack <= 0; bus_rdata <= 0; rstc <= 8'h11; chan_r <= 0; wn <= 0;
      cv <= 0; pl <= 0; ic <= 0; stat_rd <= 0; eoc_irq <= 0; dn_cnt <= 0;
    end else begin
      if (done) dn_cnt <= dn_cnt + 1;
      eoc_irq <= (ic == 1);
      if (ic != 0) ic <= ic - 1;
      bus_ack <= 0;
      if (bus_req && !bus_ack) begin
        bus_ack <= 1;
        if (bus_we) begin
          wl_a[wn] <= bus_addr; wl_d[wn] <= bus_wdata; wn <= wn + 8'd1;
          if (bus_addr == 8'h11) chan_r <= bus_wdata;
          if (bus_addr == 8'h31) rstc <= bus_wdata;
          if (bus_addr == 8'h17) begin cv <= pick(chan_r); pl <= poll_dly; ic <= irq_dly; end
        end else begin
          case (bus_addr)
            8'h01: bus_rdata <= type_v;
            8'h02: bus_rdata <= sub_v;
            8'h03: bus_rdata <= rev_v;
            8'h08: begin
              stat_rd <= stat_rd + 1;
              if (bad_stat || pl != 0) begin bus_rdata <= 8'h02; if (pl != 0) pl <= pl - 1; end
              else bus_rdata <= 8'hFD;
            end
            8'h20: bus_rdata <= cv[7:0];
            8'h21: bus_rdata <= cv[15:8];
            8'h31: bus_rdata <= rstc;
            default: bus_rdata <= 8'h00;
          endcase
        end
      end
    end
  end

  int checks = 0, errors = 0;
  int b, sr;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    chk(done, "R11 done seen", done, 1);
  endtask

  task automatic op_start();
    b = wn; sr = stat_rd;
    start = 1; @(negedge clk); start = 0;
    @(negedge clk);
    chk(!ready, "R10 ready low while busy", ready, 0);
    wait_done();
  endtask

  task automatic op_meas(input logic ch);
    b = wn; sr = stat_rd;
    meas_ch = ch; meas_req = 1; @(negedge clk); meas_req = 0;
    wait_done();
  endtask

  function automatic logic [7:0] exp_a(input int i);
    case (i)
      0: return 8'h10; 1: return 8'h11; 2: return 8'h12; 3: return 8'h13;
      4: return 8'h14; 5: return 8'h15; 6: return 8'h16; 7: return 8'h17;
      default: return 8'h16;
    endcase
  endfunction

  function automatic logic [7:0] exp_d(input int i, input logic [7:0] ch);
    case (i)
      0: return 8'h01; 1: return ch; 4: return 8'(AVG_LOG2);
      6, 7: return 8'h80; default: return 8'h00;
    endcase
  endfunction

  // Nine writes of one conversion: setup order (R5) ending with disable (R8)
  task automatic chk_conv(input int off, input logic [7:0] ch);
    for (int i = 0; i < 9; i++) begin
      logic [7:0] idx;
      idx = 8'(b + off + i);
      if (i < 8) begin
        chk(wl_a[idx] == exp_a(i), "R5 write address", wl_a[idx], exp_a(i));
        chk(wl_d[idx] == exp_d(i, ch), "R5 write data", wl_d[idx], exp_d(i, ch));
      end else begin
        chk(wl_a[idx] == 8'h16 && wl_d[idx] == 8'h00, "R8 closing disable",
            {wl_a[idx], wl_d[idx]}, 16'h1600);
      end
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(ready == 1, "R10 reset ready", ready, 1);
    chk(done == 0 && err == 0 && err_code == 0, "R11 reset flags", {done, err, err_code}, 0);
    chk(cal_ok == 0 && bus_req == 0, "R10 reset idle bus", {cal_ok, bus_req}, 0);

    // R10: request before calibration is ignored
    b = wn;
    meas_req = 1; @(negedge clk); meas_req = 0;
    repeat (20) @(negedge clk);
    chk(wn == 8'(b) && dn_cnt == 0, "R10 uncalibrated request ignored", wn - 8'(b), 0);

    // R1: identification sweep around thresholds
    for (int t = 7; t <= 8; t++)
      for (int s = 2; s <= 3; s++)
        for (int r = 0; r <= 1; r++) begin
          int ec;
          type_v = 8'(t); sub_v = 8'(s); rev_v = 8'(r);
          ec = (t < 8) ? 1 : (s < 3) ? 2 : (r < 1) ? 3 : 0;
          if (ec != 0) begin
            op_start();
            chk(err_code == 3'(ec) && err == 1, "R1 id reject code", err_code, ec);
            chk(wn == 8'(b), "R1 no writes after id reject", wn - 8'(b), 0);
            chk(cal_ok == 0, "R1 not calibrated", cal_ok, 0);
          end
        end

    // Full startup; a request while busy must be ignored (R10)
    type_v = 8; sub_v = 3; rev_v = 1;
    b = wn; sr = stat_rd;
    start = 1; @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    meas_req = 1; @(negedge clk); meas_req = 0;
    wait_done();
    chk(err == 0 && err_code == 0, "R11 startup success code", err_code, 0);
    chk(cal_ok == 1, "R3 cal_ok", cal_ok, 1);
    chk(wn - 8'(b) == 8'd30, "R3 startup write count", wn - 8'(b), 30);
    chk(wl_a[8'(b)] == 8'h30 && wl_d[8'(b)] == 8'hA5, "R2 first key", wl_d[8'(b)], 8'hA5);
    chk(wl_a[8'(b+1)] == 8'h30 && wl_d[8'(b+1)] == 8'hA5, "R2 second key", wl_d[8'(b+1)], 8'hA5);
    chk(wl_a[8'(b+2)] == 8'h31 && wl_d[8'(b+2)] == 8'h15, "R2 reset flag update", wl_d[8'(b+2)], 8'h15);
    chk_conv(3, 8'd3);
    chk_conv(12, 8'd6);
    chk_conv(21, 8'd5);
    chk(cal_gain == gain_v, "R3 gain", cal_gain, gain_v);
    chk(cal_off_int == oi_v, "R3 internal offset", cal_off_int, oi_v);
    chk(cal_off_ext == oe_v, "R3 external offset", cal_off_ext, oe_v);
    @(negedge clk);
    chk(done == 0, "R11 done one cycle", done, 0);
    b = wn;
    repeat (30) @(negedge clk);
    chk(wn == 8'(b), "R10 busy request ignored", wn - 8'(b), 0);

    // Polling sweep: channel x not-ready replies (R6, R9)
    use_irq = 0;
    for (int ch = 0; ch <= 1; ch++)
      for (int n = 0; n <= 2; n++) begin
        logic [15:0] v;
        v = 16'h1234 + 16'(ch) * 16'h0F0F + 16'(n) * 16'h0101;
        m0_v = v; m1_v = ~v; poll_dly = n;
        op_meas(1'(ch));
        chk_conv(0, 8'(ch));
        if (n < 2) begin
          chk(err == 0, "R9 measurement ok", err_code, 0);
          chk(result == (ch == 1 ? ~v : v), "R9 result", result, ch == 1 ? ~v : v);
          chk(stat_rd - sr == n + 1, "R6 status reads", stat_rd - sr, n + 1);
        end else begin
          chk(err == 1 && err_code == 3'd4, "R6 poll timeout code", err_code, 4);
          chk(stat_rd - sr == 2, "R6 retry limit", stat_rd - sr, 2);
        end
      end
    poll_dly = 0;

    // Interrupt mode (R7)
    use_irq = 1; irq_dly = 4;
    for (int ch = 0; ch <= 1; ch++) begin
      m0_v = 16'hA55A; m1_v = 16'h0FF0;
      op_meas(1'(ch));
      chk(err == 0, "R7 irq success", err_code, 0);
      chk(result == (ch == 1 ? 16'h0FF0 : 16'hA55A), "R7 irq result", result, ch == 1 ? 16'h0FF0 : 16'hA55A);
      chk(stat_rd - sr == 1, "R7 one confirming read", stat_rd - sr, 1);
      chk_conv(0, 8'(ch));
    end
    irq_dly = 0;
    op_meas(1'b0);
    chk(err == 1 && err_code == 3'd4, "R7 missing irq timeout", err_code, 4);
    chk(stat_rd - sr == 0, "R7 no status read on missing irq", stat_rd - sr, 0);
    chk_conv(0, 8'd0);
    irq_dly = 4; bad_stat = 1;
    op_meas(1'b1);
    chk(err == 1 && err_code == 3'd4, "R7 bad confirm status", err_code, 4);
    chk(stat_rd - sr == 1, "R7 bad confirm single read", stat_rd - sr, 1);
    chk_conv(0, 8'd1);
    bad_stat = 0; use_irq = 0;

    // Calibration sanity failures (R4)
    oi_v = gain_v;
    op_start();
    chk(err_code == 3'd5 && cal_ok == 0, "R4 internal offset equals gain", err_code, 5);
    chk(wn - 8'(b) == 8'd21, "R4 external offset skipped", wn - 8'(b), 21);
    chk_conv(12, 8'd6);
    oi_v = 16'h0100; oe_v = gain_v;
    op_start();
    chk(err_code == 3'd6 && cal_ok == 0, "R4 external offset equals gain", err_code, 6);
    chk(wn - 8'(b) == 8'd30, "R4 three conversions", wn - 8'(b), 30);
    b = wn;
    meas_req = 1; @(negedge clk); meas_req = 0;
    repeat (20) @(negedge clk);
    chk(wn == 8'(b), "R10 request after failed cal ignored", wn - 8'(b), 0);

    // Recover and measure once more
    oe_v = 16'h0180;
    op_start();
    chk(cal_ok == 1 && err == 0, "R3 recalibration", cal_ok, 1);
    m1_v = 16'hFFFF;
    op_meas(1'b1);
    chk(result == 16'hFFFF && err == 0, "R9 full-scale result", result, 16'hFFFF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule